// File: doc/BRIEF.md
# USB Device Address Register with Deferred Activation

This block keeps two copies of the USB device address. The first is the register that firmware programs and reads back. The second is the address and enable pair that the device actually answers to on the bus. Firmware reaches the register over a byte-wide command port. It sends a command byte first, then one data byte that is either written or read.

A write does not change the bus address immediately. It only arms an activation. The armed value moves into the live copy when the host acknowledges the zero-length status packet of the Set Address request. The surrounding protocol logic reports that event with a one-cycle strobe.

A USB bus reset clears the live address to zero, enables the device and drops any armed activation. It leaves the firmware register untouched. A token comparator raises a match output when an incoming token is addressed to the live address while the device is enabled.

Top module: `usb_addr_defer`

## Requirements
- R1: After `rst_n` is released, the firmware register reads 00h, the live address is 0, `dev_enable` is 0, `arm_pending` is 0 and `addr_match` is 0.
- R2: A command byte B6h followed by a data byte loads that data byte into the firmware register. Bit 7 of the register is the enable and bits 6:0 are the address. A command byte B7h followed by a read strobe presents the register on `cp_rdata` during the read strobe. Outside a read phase, `cp_rdata` is 00h.
- R3: A data byte that does not directly follow command B6h leaves the firmware register unchanged. This covers a data byte with no command before it and a data byte after any other code.
- R4: Loading the register sets `arm_pending` on the next cycle. The live address and `dev_enable` do not change at that point.
- R5: A `status_ack` strobe while `arm_pending` is 1 copies register bits 6:0 into `active_addr` and bit 7 into `dev_enable` on the next cycle, and clears `arm_pending`.
- R6: A `status_ack` strobe while `arm_pending` is 0 changes neither the live address nor `dev_enable`.
- R7: A `bus_reset` strobe sets `active_addr` to 0 and `dev_enable` to 1, and clears `arm_pending` on the next cycle. The firmware register is not changed.
- R8: When `bus_reset` and `status_ack` arrive in the same cycle, the bus reset wins. An activation armed before that cycle is then never applied.
- R9: `addr_match` is 1 exactly when `dev_enable` is 1, `tok_valid` is 1 and `tok_addr` equals `active_addr`. With the default `MATCH_REG = 0` it is combinational.
- R10: If a register load and a pending `status_ack` fall in the same cycle, the live copy takes the register value from before the load, and `arm_pending` stays 1 for the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cp_wr | input | 1 | Byte write strobe on the command port |
| cp_is_cmd | input | 1 | 1: the written byte is a command code, 0: it is a data byte |
| cp_wdata | input | 8 | Byte written by firmware |
| cp_rd | input | 1 | Data read strobe |
| cp_rdata | output | 8 | Read data, valid during a read strobe that follows B7h |
| status_ack | input | 1 | One-cycle pulse: host acknowledged the empty status packet |
| bus_reset | input | 1 | One-cycle pulse: USB bus reset detected |
| tok_valid | input | 1 | Incoming token address is valid |
| tok_addr | input | 7 | Address field of the incoming token |
| active_addr | output | 7 | Address currently live on the bus |
| dev_enable | output | 1 | Device enabled on the bus |
| arm_pending | output | 1 | A written address is waiting for status-stage acknowledge |
| addr_match | output | 1 | Token is for this device |

## Verification
The bench checks that a write leaves the live address untouched until the acknowledge. A design that activated at once would show the new address one transaction early. It sends acknowledges with nothing armed and acknowledges together with a bus reset, which catches a design that replays a stale write after a reset or lets the acknowledge beat the reset. It also loads a new value in the same cycle as a pending acknowledge, to catch a design that skips the old value or drops the new arm. Stray data bytes and unknown codes are sent to catch a decoder that writes the register without the proper command. Enable-clear values check that the match output stays low when the address matches but the device is disabled.

// File: rtl/usbaddr_pkg.sv
package usbaddr_pkg;
   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_WR   = 2'd1,
      PH_RD   = 2'd2
   } cmd_phase_t;

   localparam int unsigned ADDR_W_DEF = 7;
   localparam logic [7:0]  CODE_WR_DEF = 8'hB6;
   localparam logic [7:0]  CODE_RD_DEF = 8'hB7;
endpackage

// File: rtl/uad_cmd_port.sv
module uad_cmd_port
   import usbaddr_pkg::*;
#(
   parameter int unsigned DATA_W  = 8,
   parameter logic [DATA_W-1:0] CODE_WR = CODE_WR_DEF,
   parameter logic [DATA_W-1:0] CODE_RD = CODE_RD_DEF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cp_wr,
   input  logic              cp_is_cmd,
   input  logic [DATA_W-1:0] cp_wdata,
   input  logic              cp_rd,
   input  logic [DATA_W-1:0] reg_q,
   output logic              reg_we,
   output logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] cp_rdata
);
   cmd_phase_t phase_q, phase_d;

   always_comb begin
      phase_d = phase_q;
      if (cp_wr && cp_is_cmd) begin
         if (cp_wdata == CODE_WR)      phase_d = PH_WR;
         else if (cp_wdata == CODE_RD) phase_d = PH_RD;
         else                          phase_d = PH_IDLE;
      end else if (cp_wr && !cp_is_cmd) begin
         phase_d = PH_IDLE;
      end else if (cp_rd) begin
         phase_d = PH_IDLE;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) phase_q <= PH_IDLE;
      else        phase_q <= phase_d;
   end

   assign reg_we    = cp_wr && !cp_is_cmd && (phase_q == PH_WR);
   assign reg_wdata = cp_wdata;
   assign cp_rdata  = (cp_rd && phase_q == PH_RD) ? reg_q : '0;
endmodule

// File: rtl/uad_fw_reg.sv
module uad_fw_reg #(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] q
);
   always_ff @(posedge clk) begin
      if (!rst_n)  q <= '0;
      else if (we) q <= wdata;
   end
endmodule

// File: rtl/uad_activate.sv
module uad_activate #(
   parameter int unsigned ADDR_W = 7,
   localparam int unsigned DATA_W = ADDR_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] reg_q,
   input  logic              reg_we,
   input  logic              status_ack,
   input  logic              bus_reset,
   output logic [ADDR_W-1:0] active_addr,
   output logic              dev_enable,
   output logic              pending
);
   logic take;
   assign take = status_ack && pending;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active_addr <= '0;
         dev_enable  <= 1'b0;
         pending     <= 1'b0;
      end else if (bus_reset) begin
         active_addr <= '0;
         dev_enable  <= 1'b1;
         pending     <= 1'b0;
      end else begin
         if (take) begin
            active_addr <= reg_q[ADDR_W-1:0];
            dev_enable  <= reg_q[DATA_W-1];
         end
         if (reg_we)    pending <= 1'b1;
         else if (take) pending <= 1'b0;
      end
   end
endmodule

// File: rtl/uad_match.sv
module uad_match #(
   parameter int unsigned ADDR_W    = 7,
   parameter bit          MATCH_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              dev_enable,
   input  logic [ADDR_W-1:0] active_addr,
   input  logic              tok_valid,
   input  logic [ADDR_W-1:0] tok_addr,
   output logic              addr_match
);
   logic hit;
   assign hit = dev_enable && tok_valid && (tok_addr == active_addr);

   if (MATCH_REG) begin : g_reg
      logic hit_q;
      always_ff @(posedge clk) begin
         if (!rst_n) hit_q <= 1'b0;
         else        hit_q <= hit;
      end
      assign addr_match = hit_q;
   end else begin : g_comb
      assign addr_match = hit;
   end
endmodule

// File: rtl/usb_addr_defer.sv
module usb_addr_defer
   import usbaddr_pkg::*;
#(
   parameter int unsigned ADDR_W    = ADDR_W_DEF,
   parameter bit          MATCH_REG = 1'b0,
   parameter logic [7:0]  CODE_WR   = CODE_WR_DEF,
   parameter logic [7:0]  CODE_RD   = CODE_RD_DEF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cp_wr,
   input  logic              cp_is_cmd,
   input  logic [7:0]        cp_wdata,
   input  logic              cp_rd,
   output logic [7:0]        cp_rdata,
   input  logic              status_ack,
   input  logic              bus_reset,
   input  logic              tok_valid,
   input  logic [ADDR_W-1:0] tok_addr,
   output logic [ADDR_W-1:0] active_addr,
   output logic              dev_enable,
   output logic              arm_pending,
   output logic              addr_match
);
   localparam int unsigned DATA_W = ADDR_W + 1;

   if (DATA_W != 8) begin : g_bad_width
      $error("usb_addr_defer: ADDR_W plus enable bit must fill one byte");
   end
   if (CODE_WR == CODE_RD) begin : g_bad_codes
      $error("usb_addr_defer: write and read codes must differ");
   end

   logic              reg_we;
   logic [DATA_W-1:0] reg_wdata;
   logic [DATA_W-1:0] fw_reg;

   uad_cmd_port #(.DATA_W(DATA_W), .CODE_WR(CODE_WR), .CODE_RD(CODE_RD)) u_cmd (
      .clk(clk), .rst_n(rst_n), .cp_wr(cp_wr), .cp_is_cmd(cp_is_cmd),
      .cp_wdata(cp_wdata), .cp_rd(cp_rd), .reg_q(fw_reg),
      .reg_we(reg_we), .reg_wdata(reg_wdata), .cp_rdata(cp_rdata)
   );

   uad_fw_reg #(.DATA_W(DATA_W)) u_reg (
      .clk(clk), .rst_n(rst_n), .we(reg_we), .wdata(reg_wdata), .q(fw_reg)
   );

   uad_activate #(.ADDR_W(ADDR_W)) u_act (
      .clk(clk), .rst_n(rst_n), .reg_q(fw_reg), .reg_we(reg_we),
      .status_ack(status_ack), .bus_reset(bus_reset),
      .active_addr(active_addr), .dev_enable(dev_enable), .pending(arm_pending)
   );

   uad_match #(.ADDR_W(ADDR_W), .MATCH_REG(MATCH_REG)) u_match (
      .clk(clk), .rst_n(rst_n), .dev_enable(dev_enable), .active_addr(active_addr),
      .tok_valid(tok_valid), .tok_addr(tok_addr), .addr_match(addr_match)
   );
endmodule

// File: rtl/usb_addr_defer_chk.sv
module usb_addr_defer_chk #(
   parameter int unsigned ADDR_W    = 7,
   parameter bit          MATCH_REG = 1'b0,
   localparam int unsigned DATA_W   = ADDR_W + 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              status_ack,
   input logic              bus_reset,
   input logic              reg_we,
   input logic [DATA_W-1:0] fw_reg,
   input logic [ADDR_W-1:0] active_addr,
   input logic              dev_enable,
   input logic              arm_pending,
   input logic              tok_valid,
   input logic [ADDR_W-1:0] tok_addr,
   input logic              addr_match
);
   assert_arm_R4: assert property (@(posedge clk) disable iff (!rst_n)
      reg_we && !bus_reset |=> arm_pending);

   assert_take_R5: assert property (@(posedge clk) disable iff (!rst_n)
      status_ack && arm_pending && !bus_reset |=>
         active_addr == $past(fw_reg[ADDR_W-1:0]) && dev_enable == $past(fw_reg[DATA_W-1]));

   assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_reset && !(status_ack && arm_pending) |=> $stable(active_addr) && $stable(dev_enable));

   assert_busrst_R7: assert property (@(posedge clk) disable iff (!rst_n)
      bus_reset |=> active_addr == '0 && dev_enable && !arm_pending);

   assert_reg_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_we |=> $stable(fw_reg));

   if (!MATCH_REG) begin : g_match_chk
      assert_match_R9: assert property (@(posedge clk) disable iff (!rst_n)
         addr_match == (dev_enable && tok_valid && tok_addr == active_addr));
   end
endmodule

bind usb_addr_defer usb_addr_defer_chk #(.ADDR_W(ADDR_W), .MATCH_REG(MATCH_REG)) u_chk (
   .clk(clk), .rst_n(rst_n), .status_ack(status_ack), .bus_reset(bus_reset),
   .reg_we(reg_we), .fw_reg(fw_reg), .active_addr(active_addr),
   .dev_enable(dev_enable), .arm_pending(arm_pending), .tok_valid(tok_valid),
   .tok_addr(tok_addr), .addr_match(addr_match)
);

// File: tb/tb_usb_addr_defer.sv
module tb_usb_addr_defer;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cp_wr = 0, cp_is_cmd = 0, cp_rd = 0;
   logic [7:0] cp_wdata = '0;
   logic [7:0] cp_rdata;
   logic       status_ack = 0, bus_reset = 0, tok_valid = 0;
   logic [6:0] tok_addr = '0;
   logic [6:0] active_addr;
   logic       dev_enable, arm_pending, addr_match;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;

   always #10 clk = ~clk;

   usb_addr_defer dut (
      .clk(clk), .rst_n(rst_n), .cp_wr(cp_wr), .cp_is_cmd(cp_is_cmd),
      .cp_wdata(cp_wdata), .cp_rd(cp_rd), .cp_rdata(cp_rdata),
      .status_ack(status_ack), .bus_reset(bus_reset), .tok_valid(tok_valid),
      .tok_addr(tok_addr), .active_addr(active_addr), .dev_enable(dev_enable),
      .arm_pending(arm_pending), .addr_match(addr_match)
   );

   localparam int NV = 6;
   localparam logic [7:0] VEC [NV] = '{8'h85, 8'h7F, 8'h80, 8'hFF, 8'hAA, 8'h01};

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr_byte(input logic is_cmd, input logic [7:0] b, input logic ack);
      @(negedge clk);
      cp_wr = 1; cp_is_cmd = is_cmd; cp_wdata = b; status_ack = ack;
      @(negedge clk);
      cp_wr = 0; cp_is_cmd = 0; cp_wdata = '0; status_ack = 0;
   endtask

   task automatic fw_write(input logic [7:0] v);
      wr_byte(1'b1, 8'hB6, 1'b0);
      wr_byte(1'b0, v, 1'b0);
   endtask

   task automatic fw_read(output logic [7:0] v);
      wr_byte(1'b1, 8'hB7, 1'b0);
      @(negedge clk);
      cp_rd = 1;
      #1 v = cp_rdata;
      @(negedge clk);
      cp_rd = 0;
   endtask

   task automatic strobe(input logic ack, input logic brst);
      @(negedge clk);
      status_ack = ack; bus_reset = brst;
      @(negedge clk);
      status_ack = 0; bus_reset = 0;
   endtask

   task automatic tok_check(input string req, input logic [6:0] a, input logic exp);
      tok_valid = 1; tok_addr = a;
      #1 chk(req, addr_match, exp);
      tok_valid = 0;
      #1;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [7:0] rd;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      fw_read(rd);
      chk("R1 reg", rd, 8'h00);
      chk("R1 addr", active_addr, 0);
      chk("R1 en", dev_enable, 0);
      chk("R1 pend", arm_pending, 0);
      tok_check("R1 match", 7'd0, 1'b0);

      // Vector walk: R2, R4, R5, R9
      for (int i = 0; i < NV; i++) begin
         logic [6:0] prev_a;
         logic       prev_e;
         prev_a = active_addr; prev_e = dev_enable;
         fw_write(VEC[i]);
         chk("R4 pend", arm_pending, 1);
         chk("R4 addr held", active_addr, prev_a);
         chk("R4 en held", dev_enable, prev_e);
         fw_read(rd);
         chk("R2 readback", rd, VEC[i]);
         chk("R2 idle rdata", cp_rdata, 8'h00);
         strobe(1'b1, 1'b0);
         chk("R5 addr", active_addr, VEC[i][6:0]);
         chk("R5 en", dev_enable, VEC[i][7]);
         chk("R5 pend clr", arm_pending, 0);
         tok_check("R9 hit", VEC[i][6:0], VEC[i][7]);
         tok_check("R9 miss", VEC[i][6:0] ^ 7'h01, 1'b0);
      end
      // state now: reg=01, active=01, en=0

      // R3 stray data bytes
      wr_byte(1'b0, 8'hC3, 1'b0);
      wr_byte(1'b1, 8'h55, 1'b0);
      wr_byte(1'b0, 8'h99, 1'b0);
      wr_byte(1'b1, 8'hB6, 1'b0);
      wr_byte(1'b0, 8'h8C, 1'b0);
      wr_byte(1'b0, 8'h9D, 1'b0); // second data byte without new code
      fw_read(rd);
      chk("R3 reg", rd, 8'h8C);
      chk("R3 pend", arm_pending, 1);
      strobe(1'b1, 1'b0);
      chk("R3 addr", active_addr, 7'h0C);

      // R6 ack without pending
      strobe(1'b1, 1'b0);
      chk("R6 addr", active_addr, 7'h0C);
      chk("R6 en", dev_enable, 1);
      chk("R6 pend", arm_pending, 0);

      // R7/R8 bus reset together with ack while armed
      fw_write(8'h93);
      strobe(1'b1, 1'b1);
      chk("R8 addr", active_addr, 0);
      chk("R8 en", dev_enable, 1);
      chk("R7 pend", arm_pending, 0);
      fw_read(rd);
      chk("R7 reg kept", rd, 8'h93);
      strobe(1'b1, 1'b0);
      chk("R8 stale not applied", active_addr, 0);
      tok_check("R9 after reset", 7'd0, 1'b1);

      // R7 bus reset alone from a disabled state
      fw_write(8'h15);
      strobe(1'b1, 1'b0);
      chk("R7 pre en", dev_enable, 0);
      strobe(1'b0, 1'b1);
      chk("R7 en", dev_enable, 1);
      chk("R7 addr", active_addr, 0);

      // R10 load and pending ack in the same cycle
      fw_write(8'h91);
      wr_byte(1'b1, 8'hB6, 1'b0);
      wr_byte(1'b0, 8'hC4, 1'b1);
      chk("R10 old value", active_addr, 7'h11);
      chk("R10 en", dev_enable, 1);
      chk("R10 pend kept", arm_pending, 1);
      strobe(1'b1, 1'b0);
      chk("R10 new value", active_addr, 7'h44);
      chk("R10 pend clr", arm_pending, 0);

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule